// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single output-compare channel for a general-purpose timer. An external counter supplies its current count, its counting direction, a count-enable qualifier and an update-event strobe. The channel holds an active compare value and a shadow copy of it. It also holds a small control byte that selects one of eight behaviours. From these inputs it produces a registered reference level, which later stages can condition further.

Software programs the channel through two write strobes. One strobe writes the control byte and the other writes the compare value. When preloading is enabled, compare writes land in the shadow and become active only on an update event. Otherwise they take effect at once. The active compare value is brought out so that the preload path can be observed.

Top module: `oc_channel`

## Requirements
- R1: After reset, `oc_ref` is 0, `cmp_active` is 0, the behaviour is frozen and preloading is off.
- R2: In the control byte, bits [6:4] hold the behaviour code and bit 3 enables preloading. Bits 7, 2, 1 and 0 are accepted but change nothing.
- R3: Code 0 (frozen): `oc_ref` keeps its level whatever the counter does.
- R4: Code 1 (set on match): on a match event, `oc_ref` becomes 1 at the next edge. A match event is the first of a run of consecutive cycles in which `cnt_en` is 1 and `cnt_val` equals `cmp_active`.
- R5: Code 2 (clear on match): on a match event, `oc_ref` becomes 0 at the next edge.
- R6: Code 3 (toggle): `oc_ref` inverts once per match event. Further consecutive matching cycles do not invert it again.
- R7: Codes 4 and 5 force `oc_ref` to 0 and 1 respectively, regardless of the counter. The forced level appears at the edge after the edge that stores the code.
- R8: Code 6 while counting up (`cnt_down`=0): `oc_ref` takes the value of (`cnt_val` < `cmp_active`) at the next edge.
- R9: Code 6 while counting down (`cnt_down`=1): `oc_ref` is 0 when `cnt_val` > `cmp_active` and 1 otherwise, registered one edge later.
- R10: Code 7 yields the inverse of code 6 in both directions.
- R11: With preloading off, a compare write appears on `cmp_active` at the edge that accepts it.
- R12: With preloading on, a compare write goes only to the shadow. `cmp_active` takes the shadow value at an edge where `upd_evt` is 1. If a write and an update share an edge, the shadow value from before the write is loaded.
- R13: While `cnt_en` is 0, equality of count and compare causes no set, clear or toggle action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 when the counter is counting down |
| cnt_en | input | 1 | Counter is running this cycle |
| upd_evt | input | 1 | Update-event strobe from the counter |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| oc_ref | output | 1 | Registered reference level |
| cmp_active | output | CNT_W | Active compare value |

## Verification
A compare write with preloading off shows on `cmp_active` after the one edge that accepts it. A shadowed value shows after the edge that carries `upd_evt`. Match actions and PWM levels pass through one register, so `oc_ref` reflects the inputs present at the previous edge. Forced levels need two edges from the control write: one to store the code and one to drive the level. The bench's model advances at every rising edge using exactly those latencies, and both outputs are compared against it at the following falling edge, so each result is sampled in the cycle it becomes due.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int CTL_W     = 8;
    localparam int MODE_LSB  = 4;
    localparam int MODE_W    = 3;
    localparam int PRE_BIT   = 3;

    typedef enum logic [MODE_W-1:0] {
        OM_FROZEN = 3'd0,
        OM_SET    = 3'd1,
        OM_CLR    = 3'd2,
        OM_TOG    = 3'd3,
        OM_LOW    = 3'd4,
        OM_HIGH   = 3'd5,
        OM_PWM_A  = 3'd6,
        OM_PWM_B  = 3'd7
    } oc_mode_e;
endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             upd_evt,
    output oc_mode_e         mode,
    output logic             pre_en,
    output logic [CNT_W-1:0] cmp_act
);
    typedef struct packed {
        oc_mode_e         mode;
        logic             pre;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] act;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctl_unused;

    assign ctl_unused = ^{ctl_wdata[7], ctl_wdata[2:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (ctl_we) begin
            cfg_d.mode = oc_mode_e'(ctl_wdata[MODE_LSB +: MODE_W]);
            cfg_d.pre  = ctl_wdata[PRE_BIT];
        end
        if (cfg_q.pre && upd_evt) begin
            cfg_d.act = cfg_q.shadow;
        end
        if (cmp_we) begin
            cfg_d.shadow = cmp_wdata;
            if (!cfg_q.pre) begin
                cfg_d.act = cmp_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: OM_FROZEN, pre: 1'b0, shadow: '0, act: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode    = cfg_q.mode;
    assign pre_en  = cfg_q.pre;
    assign cmp_act = cfg_q.act;
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit,
    output logic             below,
    output logic             above
);
    typedef struct packed {
        logic seen;
    } mst_t;

    mst_t m_d, m_q;
    logic eq;

    assign eq    = cnt_en && (cnt_val == cmp);
    assign hit   = eq && !m_q.seen;
    assign below = cnt_val < cmp;
    assign above = cnt_val > cmp;

    always_comb begin
        m_d      = m_q;
        m_d.seen = eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{seen: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end
endmodule

// File: rtl/oc_level.sv
module oc_level
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  oc_mode_e mode,
    input  logic     hit,
    input  logic     below,
    input  logic     above,
    input  logic     cnt_down,
    output logic     lvl
);
    typedef struct packed {
        logic lvl;
    } lst_t;

    lst_t l_d, l_q;
    logic pwm_lvl;

    assign pwm_lvl = cnt_down ? !above : below;

    always_comb begin
        l_d = l_q;
        unique case (mode)
            OM_FROZEN: l_d.lvl = l_q.lvl;
            OM_SET:    if (hit) l_d.lvl = 1'b1;
            OM_CLR:    if (hit) l_d.lvl = 1'b0;
            OM_TOG:    if (hit) l_d.lvl = !l_q.lvl;
            OM_LOW:    l_d.lvl = 1'b0;
            OM_HIGH:   l_d.lvl = 1'b1;
            OM_PWM_A:  l_d.lvl = pwm_lvl;
            OM_PWM_B:  l_d.lvl = !pwm_lvl;
            default:   l_d.lvl = l_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '{lvl: 1'b0};
        end else begin
            l_q <= l_d;
        end
    end

    assign lvl = l_q.lvl;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             cnt_en,
    input  logic             upd_evt,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             oc_ref,
    output logic [CNT_W-1:0] cmp_active
);
    oc_mode_e         mode_q;
    logic             pre_q;
    logic [CNT_W-1:0] cmp_q;
    logic             match_hit;
    logic             cnt_below;
    logic             cnt_above;

    oc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .upd_evt   (upd_evt),
        .mode      (mode_q),
        .pre_en    (pre_q),
        .cmp_act   (cmp_q)
    );

    oc_match #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_val (cnt_val),
        .cnt_en  (cnt_en),
        .cmp     (cmp_q),
        .hit     (match_hit),
        .below   (cnt_below),
        .above   (cnt_above)
    );

    oc_level u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .hit      (match_hit),
        .below    (cnt_below),
        .above    (cnt_above),
        .cnt_down (cnt_down),
        .lvl      (oc_ref)
    );

    assign cmp_active = cmp_q;
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             pre,
    input logic             hit,
    input logic             cnt_down,
    input logic [CNT_W-1:0] cnt_val,
    input logic             upd_evt,
    input logic             cmp_we,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic [CNT_W-1:0] cmp_active,
    input logic             oc_ref
);
    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> $stable(oc_ref));
    // R4
    set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && hit) |=> oc_ref);
    // R5
    clr_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && hit) |=> !oc_ref);
    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && hit) |=> (oc_ref != $past(oc_ref)));
    // R6
    toggle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && !hit) |=> $stable(oc_ref));
    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> !oc_ref);
    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5) |=> oc_ref);
    // R8
    pwm_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && !cnt_down) |=> (oc_ref == $past(cnt_val < cmp_active)));
    // R10
    pwm_inv_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7 && !cnt_down) |=> (oc_ref == $past(cnt_val >= cmp_active)));
    // R11
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre && cmp_we) |=> (cmp_active == $past(cmp_wdata)));
    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !upd_evt) |=> $stable(cmp_active));
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .pre        (pre_q),
    .hit        (match_hit),
    .cnt_down   (cnt_down),
    .cnt_val    (cnt_val),
    .upd_evt    (upd_evt),
    .cmp_we     (cmp_we),
    .cmp_wdata  (cmp_wdata),
    .cmp_active (cmp_active),
    .oc_ref     (oc_ref)
);

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
    localparam int CNT_W  = 16;
    localparam int PERIOD = 10;
    localparam int WRAP   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             cnt_down = 1'b0;
    logic             cnt_en = 1'b0;
    logic             upd_evt = 1'b0;
    logic             ctl_we = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic             cmp_we = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic             oc_ref;
    logic [CNT_W-1:0] cmp_active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag_over = "";

    // behavioural reference state
    int m_mode = 0;
    bit m_pre = 0;
    int m_act = 0;
    int m_sh = 0;
    bit m_ref = 0;
    bit m_seen = 0;

    always #(PERIOD/2) clk = ~clk;

    oc_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .cnt_en(cnt_en), .upd_evt(upd_evt), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .oc_ref(oc_ref), .cmp_active(cmp_active)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_pre = 0; m_act = 0; m_sh = 0; m_ref = 0; m_seen = 0;
        end else begin
            bit eq;
            bit ev;
            int nact;
            eq = cnt_en && (int'(cnt_val) == m_act);
            ev = eq && !m_seen;
            m_seen = eq;
            case (m_mode)
                1: if (ev) m_ref = 1;
                2: if (ev) m_ref = 0;
                3: if (ev) m_ref = !m_ref;
                4: m_ref = 0;
                5: m_ref = 1;
                6: m_ref = cnt_down ? !(int'(cnt_val) > m_act) : (int'(cnt_val) < m_act);
                7: m_ref = cnt_down ? (int'(cnt_val) > m_act) : !(int'(cnt_val) < m_act);
                default: ;
            endcase
            nact = m_act;
            if (m_pre && upd_evt) nact = m_sh;
            if (cmp_we) begin
                if (!m_pre) nact = int'(cmp_wdata);
                m_sh = int'(cmp_wdata);
            end
            m_act = nact;
            if (ctl_we) begin
                m_mode = int'(ctl_wdata[6:4]);
                m_pre = ctl_wdata[3];
            end
        end
    end

    function automatic string ref_tag();
        if (tag_over != "") return tag_over;
        case (m_mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            6: return cnt_down ? "R9" : "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check_all();
        total++;
        if (oc_ref !== m_ref) begin
            bad++;
            $display("FAIL %s oc_ref actual=%0b expected=%0b t=%0t", ref_tag(), oc_ref, m_ref, $time);
        end
        total++;
        if (int'(cmp_active) != m_act) begin
            bad++;
            $display("FAIL %s cmp_active actual=%0d expected=%0d t=%0t",
                     m_pre ? "R12" : "R11", cmp_active, m_act, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
        ctl_we = 0; cmp_we = 0; upd_evt = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v;
        tick();
    endtask

    task automatic wr_cmp(input int v);
        cmp_we = 1; cmp_wdata = CNT_W'(v);
        tick();
    endtask

    task automatic run(input int n, input bit down, input bit en);
        cnt_down = down; cnt_en = en;
        for (int i = 0; i < n; i++) begin
            if (down) cnt_val = (cnt_val == 0) ? CNT_W'(WRAP - 1) : cnt_val - 1'b1;
            else      cnt_val = (cnt_val >= CNT_W'(WRAP - 1)) ? '0 : cnt_val + 1'b1;
            upd_evt = down ? (cnt_val == 0) : (cnt_val == CNT_W'(WRAP - 1));
            tick();
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        tag_over = "R1";
        check_all();
        rst_n = 1;
        tick();
        tag_over = "";
        // R11 direct compare load
        wr_cmp(10);
        // R4 set on match
        wr_ctl(8'h10);
        run(25, 0, 1);
        // R5 clear on match
        wr_ctl(8'h20);
        run(25, 0, 1);
        // R6 toggle; counter parked on the compare value
        wr_ctl(8'h30);
        run(45, 0, 1);
        cnt_val = 16'd10; cnt_en = 1;
        for (int i = 0; i < 5; i++) tick();
        // R13 disabled counter passes compare without action
        tag_over = "R13";
        run(25, 0, 0);
        tag_over = "";
        // R7 forced levels
        wr_ctl(8'h50);
        run(3, 0, 1);
        wr_ctl(8'h40);
        run(3, 0, 1);
        // R3 frozen keeps level
        wr_ctl(8'h50);
        tick();
        wr_ctl(8'h00);
        run(25, 0, 1);
        // R8 / R9 PWM mode 1 both directions
        wr_ctl(8'h60);
        run(45, 0, 1);
        run(45, 1, 1);
        // R10 inverse PWM
        wr_ctl(8'h70);
        run(45, 0, 1);
        run(45, 1, 1);
        // R12 preload path
        wr_ctl(8'h68);
        wr_cmp(4);
        run(8, 0, 1);
        wr_cmp(15);
        run(30, 0, 1);
        tag_over = "R12";
        cmp_we = 1; cmp_wdata = 16'd7; upd_evt = 1;
        tick();
        tick();
        upd_evt = 1;
        tick();
        tag_over = "";
        // R2 ignored control bits alongside force high
        tag_over = "R2";
        wr_ctl(8'hD7);
        tick();
        wr_cmp(3);
        tick();
        tag_over = "";
        run(20, 1, 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule